// File: doc/BRIEF.md
# Digit-Serial Constant Left Shifter

This block scales a digit-serial data stream by a fixed power of two, 2^LS. The shift amount LS and the digit width D are compile-time parameters. Words arrive one D-bit digit per clock, least significant digit first. Inside a digit, bit 0 is the least significant bit and bit D-1 the most significant. The shift is built only from D flip-flops. Each output bit lane takes its bit from a rotated input lane and passes it through a delay chain whose depth depends on the lane. The chains together hold exactly LS flip-flops, and the block has no adders.

The shifted stream leaves the block digit-aligned with the input. The output digit for stream position k appears in the same cycle that input digit k is applied. A start pulse, given with the first digit of a word, clears all chain contents for that word, so the lowest LS bits of the result are zero. If no start pulse is given, the stream is treated as continuous, and the top LS bits of the previous word flow into the low end of the next one. A synchronous active-high reset also empties every chain.

Top module: `dshift_const_lshift`

## Requirements
- R1: With start asserted on the first digit of a W-bit word, the output digits of that word, reassembled least significant digit first, equal (x << LS) mod 2^W.
- R2: Output bit lane i is fed from input lane j = (i - LS) mod D, delayed by (LS + j - i)/D clock cycles. A single set bit at any stream position b appears only at output position b + LS.
- R3: In the cycle where start is high, every output lane whose delay is at least one cycle reads 0, whatever the preceding word held. The LS low-order bits of a word started this way are all zero.
- R4: Without a start pulse, the stream is continuous. The LS low-order output bits of a word are the LS high-order bits of the previous word.
- R5: A synchronous active-high reset clears every delay stage. A word sent after reset without a start pulse has zero fill in its LS low-order bits.
- R6: The output digit for stream digit k is valid in the same clock cycle as input digit k. Lanes with zero delay pass the input bit straight through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High with the first digit of a word; clears the chains for that word |
| din | input | D | Input digit, least significant digit of the word first |
| dout | output | D | Shifted output digit, aligned with din |

## Verification
The hardest case is a start pulse that arrives while every delay stage still holds ones from the preceding word. A correct design must then mask both the chain outputs and the stage-to-stage transfers. The stimulus streams an all-ones word and follows it directly with a started word. A single-bit impulse is then swept across every stream position, which exercises each lane's source rotation and delay depth. These tests run across several digit widths and shift amounts, including shifts larger than the digit.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

  // Input lane that feeds output lane i: (i - ls) mod d, kept non-negative.
  function automatic int src_lane(input int i, input int d, input int ls);
    return (i + d - (ls % d)) % d;
  endfunction

  // Whole-digit delay seen by output lane i. (ls + j - i) is always a
  // non-negative multiple of d.
  function automatic int lane_depth(input int i, input int d, input int ls);
    int j;
    j = src_lane(i, d, ls);
    return (ls + j - i) / d;
  endfunction

endpackage

// File: rtl/dshift_lane_router.sv
module dshift_lane_router
  import dshift_pkg::*;
#(
  parameter int D  = 2,
  parameter int LS = 5
) (
  input  logic [D-1:0] din,
  output logic [D-1:0] routed
);

  // Rotate the digit so that each output lane sees its source bit.
  for (genvar i = 0; i < D; i++) begin : g_route
    localparam int SRC = src_lane(i, D, LS);
    assign routed[i] = din[SRC];
  end

endmodule

// File: rtl/dshift_lane_chain.sv
module dshift_lane_chain #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_in,
  output logic bit_out
);

  logic [DEPTH-1:0] stg;

  // The first stage always captures the incoming bit of the current word.
  always_ff @(posedge clk) begin
    if (rst) stg[0] <= 1'b0;
    else     stg[0] <= bit_in;
  end

  // Later stages take the previous stage, or zero when a new word begins.
  if (DEPTH > 1) begin : g_tail
    always_ff @(posedge clk) begin
      if (rst)      stg[DEPTH-1:1] <= '0;
      else if (clr) stg[DEPTH-1:1] <= '0;
      else          stg[DEPTH-1:1] <= stg[DEPTH-2:0];
    end
  end

  // On the start cycle the stale tail belongs to the old word: mask it.
  assign bit_out = clr ? 1'b0 : stg[DEPTH-1];

endmodule

// File: rtl/dshift_const_lshift.sv
module dshift_const_lshift
  import dshift_pkg::*;
#(
  parameter int D  = 2,
  parameter int LS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [D-1:0] din,
  output logic [D-1:0] dout
);

  logic [D-1:0] routed;

  dshift_lane_router #(.D(D), .LS(LS)) u_router (
    .din    (din),
    .routed (routed)
  );

  for (genvar i = 0; i < D; i++) begin : g_lane
    localparam int DEPTH = lane_depth(i, D, LS);
    if (DEPTH == 0) begin : g_wire
      assign dout[i] = routed[i];
    end else begin : g_dly
      dshift_lane_chain #(.DEPTH(DEPTH)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .bit_in  (routed[i]),
        .bit_out (dout[i])
      );
    end
  end

endmodule

// File: rtl/dshift_const_lshift_chk.sv
module dshift_const_lshift_chk
  import dshift_pkg::*;
#(
  parameter int D  = 2,
  parameter int LS = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [D-1:0] din,
  input logic [D-1:0] dout
);

  for (genvar i = 0; i < D; i++) begin : g_lane
    localparam int J = src_lane(i, D, LS);
    localparam int Q = lane_depth(i, D, LS);

    if (Q > 0) begin : g_delayed
      AST_START_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        start |-> (dout[i] == 1'b0)); // R3
      AST_RESET_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout[i] == 1'b0)); // R5
    end

    if (Q == 1) begin : g_one
      AST_ONE_DIGIT_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!start && !$past(rst)) |-> (dout[i] == $past(din[J]))); // R2
    end

    if (Q == 0) begin : g_pass
      AST_SAME_CYCLE_PASS: assert property (@(posedge clk) disable iff (rst)
        dout[i] == din[J]); // R6
    end
  end

endmodule

bind dshift_const_lshift dshift_const_lshift_chk #(.D(D), .LS(LS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .din   (din),
  .dout  (dout)
);

// File: tb/dshift_const_lshift_test.sv
module dshift_cfg_harness #(
  parameter int D    = 2,
  parameter int LS   = 5,
  parameter int W    = 12,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   n_checks,
  output int   n_errs
);

  localparam int ND = W / D;

  logic         start;
  logic [D-1:0] din;
  logic [D-1:0] dout;
  logic [W-1:0] hist;
  logic [31:0]  lcg;

  dshift_const_lshift #(.D(D), .LS(LS)) uut (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .din   (din),
    .dout  (dout)
  );

  function automatic logic [W-1:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return W'(lcg >> 7);
  endfunction

  // Stream one word and compare the reassembled output with the model.
  task automatic run_word(input logic [W-1:0] x, input logic st, input string tag);
    logic [W-1:0]   got;
    logic [W-1:0]   prev;
    logic [2*W-1:0] cat;
    logic [W-1:0]   exp_w;
    prev  = st ? '0 : hist;
    cat   = {x, prev};
    exp_w = W'((cat << LS) >> W);
    got   = '0;
    for (int k = 0; k < ND; k++) begin
      @(negedge clk);
      start = st && (k == 0);
      din   = x[k*D +: D];
      #2;
      got[k*D +: D] = dout;
    end
    hist = x;
    n_checks++;
    if (got !== exp_w) begin
      n_errs++;
      $display("FAIL %s D=%0d LS=%0d x=%h: got %h expected %h", tag, D, LS, x, got, exp_w);
    end
  endtask

  task automatic t_reset_fill();     // R5
    run_word(rnd() | W'(1 << (W-1)), 1'b0, "R5");
  endtask

  task automatic t_random_start();   // R1
    for (int n = 0; n < 6; n++) run_word(rnd(), 1'b1, "R1");
  endtask

  task automatic t_start_after_ones(); // R3
    run_word('1, 1'b1, "R3");
    run_word('1, 1'b1, "R3");
  endtask

  task automatic t_no_start_carry(); // R4
    run_word(rnd() | W'(1 << (W-1)), 1'b1, "R4");
    run_word(rnd(), 1'b0, "R4");
  endtask

  task automatic t_edge_bits();      // R1
    run_word(W'(1 << (W-1)), 1'b1, "R1");
    run_word(W'(1), 1'b1, "R1");
  endtask

  task automatic t_impulse_sweep();  // R2
    for (int b = 0; b < W; b++) run_word(W'(1 << b), 1'b1, "R2");
  endtask

  task automatic t_same_cycle();     // R6
    run_word({(W/2){2'b10}}, 1'b1, "R6");
  endtask

  initial begin
    done     = 1'b0;
    n_checks = 0;
    n_errs   = 0;
    start    = 1'b0;
    din      = '0;
    hist     = '0;
    lcg      = 32'(SEED);
    @(negedge clk);
    while (rst) @(negedge clk);
    t_reset_fill();
    t_random_start();
    t_start_after_ones();
    t_no_start_carry();
    t_edge_bits();
    t_impulse_sweep();
    t_same_cycle();
    @(negedge clk);
    start = 1'b0;
    done  = 1'b1;
  end

endmodule

module dshift_const_lshift_test;

  logic clk = 1'b0;
  logic rst = 1'b1;

  always #5 clk = ~clk;

  logic d0, d1, d2, d3, d4, d5;
  int   c0, c1, c2, c3, c4, c5;
  int   e0, e1, e2, e3, e4, e5;

  dshift_cfg_harness #(.D(2), .LS(5), .SEED(11)) cfg_d2_s5 (.clk(clk), .rst(rst), .done(d0), .n_checks(c0), .n_errs(e0));
  dshift_cfg_harness #(.D(4), .LS(2), .SEED(23)) cfg_d4_s2 (.clk(clk), .rst(rst), .done(d1), .n_checks(c1), .n_errs(e1));
  dshift_cfg_harness #(.D(3), .LS(7), .SEED(37)) cfg_d3_s7 (.clk(clk), .rst(rst), .done(d2), .n_checks(c2), .n_errs(e2));
  dshift_cfg_harness #(.D(4), .LS(4), .SEED(41)) cfg_d4_s4 (.clk(clk), .rst(rst), .done(d3), .n_checks(c3), .n_errs(e3));
  dshift_cfg_harness #(.D(1), .LS(3), .SEED(53)) cfg_d1_s3 (.clk(clk), .rst(rst), .done(d4), .n_checks(c4), .n_errs(e4));
  dshift_cfg_harness #(.D(2), .LS(1), .SEED(67)) cfg_d2_s1 (.clk(clk), .rst(rst), .done(d5), .n_checks(c5), .n_errs(e5));

  initial begin
    int cyc;
    int checks;
    int errs;
    cyc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (!(d0 && d1 && d2 && d3 && d4 && d5) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks = c0 + c1 + c2 + c3 + c4 + c5;
    errs   = e0 + e1 + e2 + e3 + e4 + e5;
    if (cyc >= 20000) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected all scenarios done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule